// File: doc/BRIEF.md
# Command FIFO Status and Interrupt Logic

This block sits beside a command FIFO tracker. It watches the tracker's read pointer, write pointer and fill distance. It compares them against a high and a low threshold and against a stop address, and from that it forms the health flags of the FIFO. The flags are reported through a 16-bit status word and through one level-sensitive interrupt request. A 16-bit control register chooses which conditions may raise the interrupt. It also holds the enable that lets the command reader fetch, a stop-address enable, and a flag that tells the producer side the FIFO is attached to the reader.

Software, or a neighbouring register block, writes the control register and reads both words through a small one-bit-address port. The thresholds and the stop address arrive as plain inputs from wherever they are stored. When the reader enable is taken away by a control write, the block emits a one-cycle flush pulse so that downstream logic can drain.

Top module: `fifo_status_irq`

## Requirements
- R1: Status bit 0 (overflow) is 1 exactly when `fill_dist` is strictly greater than `hi_mark`, compared unsigned.
- R2: Status bit 1 (underflow) is 1 exactly when `fill_dist` is strictly less than `lo_mark`, compared unsigned.
- R3: Status bit 4 (stop hit) is 1 exactly when control bit 1 (stop enable) is set and `bp_addr` equals `rd_ptr`. It is 0 whenever stop enable is clear.
- R4: Status bit 2 (reader idle) is 1 when `fill_dist` is zero or `rd_ptr` equals `wr_ptr`.
- R5: Status bit 3 (command idle) is 1 when `fill_dist` is zero, when the stop-hit flag is set, or when control bit 0 (reader enable) is clear.
- R6: `irq` is a register. After each rising edge it equals ((stop hit AND control bit 5) OR (overflow AND control bit 2) OR (underflow AND control bit 3)) AND control bit 0, evaluated with the inputs and the control value present just before that edge.
- R7: A write with `wr_addr`=0 loads control bits 5:0 on the next edge. The control layout is: bit0 reader enable, bit1 stop enable, bit2 overflow interrupt enable, bit3 underflow interrupt enable, bit4 link enable, bit5 stop interrupt enable. Bits 15:6 always read 0. `link_en` follows control bit 4.
- R8: The status word is read with `rd_addr`=1 and the control word with `rd_addr`=0. Status bits 15:5 read 0. A write with `wr_addr`=1 changes neither the control register nor the status word.
- R9: `flush` is high for exactly the one cycle after an edge at which a control write cleared reader enable while it was set. A write that leaves reader enable clear, or that keeps it set, gives no pulse.
- R10: After reset the control word reads 0, `irq` and `flush` are 0, and with zero distance, equal pointers, a zero low threshold and a nonzero stop address, the status word reads 0x000C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_ptr | input | AW | Reader pointer from the FIFO tracker |
| wr_ptr | input | AW | Writer pointer from the FIFO tracker |
| fill_dist | input | AW | Bytes queued between writer and reader |
| hi_mark | input | AW | Overflow threshold |
| lo_mark | input | AW | Underflow threshold |
| bp_addr | input | AW | Stop address compared with the reader pointer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 status (ignored) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read select: 0 control, 1 status |
| rd_data | output | 16 | Selected register word |
| irq | output | 1 | Registered interrupt request |
| flush | output | 1 | One-cycle pulse on reader-enable removal |
| link_en | output | 1 | Link enable from the control register |

## Verification
The hardest situation to bring about is a stop-address interrupt. It needs the stop enable, the stop interrupt enable and the reader enable all set in the control register, while the reader pointer lands exactly on the stop address. With full-width random pointers that almost never happens. The stimulus therefore draws pointers, the stop address, the distance and both thresholds from a range of a few values. This also makes equal pointers, zero distance, and overflow together with underflow (low threshold above high threshold) frequent. Control writes are random too, and a directed sequence removes reader enable while it is set and again while it is already clear.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int REG_W     = 16;
  localparam int CTRL_USED = 6;
  localparam int STAT_USED = 5;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // Control fields, most significant first (bit5 .. bit0)
  typedef struct packed {
    logic bp_irq_en;
    logic link_en;
    logic udf_irq_en;
    logic ovf_irq_en;
    logic bp_en;
    logic rd_en;
  } ctrl_t;

  // Status fields, most significant first (bit4 .. bit0)
  typedef struct packed {
    logic bp_hit;
    logic cmd_idle;
    logic rd_idle;
    logic udf;
    logic ovf;
  } stat_t;

  function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
    return {{(REG_W-CTRL_USED){1'b0}}, c};
  endfunction

  function automatic logic [REG_W-1:0] pack_stat(input stat_t s);
    return {{(REG_W-STAT_USED){1'b0}}, s};
  endfunction
endpackage

// File: rtl/fsi_ctrl_reg.sv
module fsi_ctrl_reg
  import fsi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [CTRL_USED-1:0] wr_bits,
  output ctrl_t                ctrl,
  output logic                 flush
);
  logic  ctrl_wr;
  logic  stat_wr;
  ctrl_t ctrl_nxt;
  logic  rden_fall;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign stat_wr   = wr_en && (wr_addr == ADDR_STAT);
  assign ctrl_nxt  = ctrl_t'(wr_bits);
  assign rden_fall = ctrl_wr && ctrl.rd_en && !ctrl_nxt.rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      flush <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_nxt;
      flush <= rden_fall;
    end
  end

  // R8: a write aimed at the status address leaves control untouched
  a_r8_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> $stable(ctrl));
  // R9: the flush pulse lasts one cycle
  a_r9_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  // R9: a pulse only follows a set-to-clear change of reader enable
  a_r9_flush_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!ctrl.rd_en && $past(ctrl.rd_en)));
endmodule

// File: rtl/fsi_flag_eval.sv
module fsi_flag_eval
  import fsi_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_ptr,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] fill_dist,
  input  logic [AW-1:0] hi_mark,
  input  logic [AW-1:0] lo_mark,
  input  logic [AW-1:0] bp_addr,
  input  ctrl_t         ctrl,
  output stat_t         stat
);
  function automatic logic exceeds(input logic [AW-1:0] v, input logic [AW-1:0] lim);
    return v > lim;
  endfunction

  function automatic logic short_of(input logic [AW-1:0] v, input logic [AW-1:0] lim);
    return v < lim;
  endfunction

  function automatic logic stop_match(input logic en, input logic [AW-1:0] p,
                                      input logic [AW-1:0] a);
    return en && (p == a);
  endfunction

  logic empty;
  logic ptr_eq;
  logic bp_evt;

  assign empty  = (fill_dist == '0);
  assign ptr_eq = (rd_ptr == wr_ptr);
  assign bp_evt = stop_match(ctrl.bp_en, rd_ptr, bp_addr);

  always_comb begin
    stat.ovf      = exceeds(fill_dist, hi_mark);
    stat.udf      = short_of(fill_dist, lo_mark);
    stat.bp_hit   = bp_evt;
    stat.rd_idle  = empty || ptr_eq;
    stat.cmd_idle = empty || bp_evt || !ctrl.rd_en;
  end

  // R3: the stop flag never appears without its enable
  a_r3_bp_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    stat.bp_hit |-> ctrl.bp_en);
  // R5: a stop hit always reports the command path idle
  a_r5_bp_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stat.bp_hit |-> stat.cmd_idle);
  // R5: without reader enable the command path is idle
  a_r5_noread_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.rd_en |-> stat.cmd_idle);
endmodule

// File: rtl/fsi_irq_gen.sv
module fsi_irq_gen
  import fsi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t stat,
  input  ctrl_t ctrl,
  output logic  irq
);
  function automatic logic irq_req(input stat_t s, input ctrl_t c);
    logic any_cause;
    any_cause = (s.bp_hit && c.bp_irq_en) ||
                (s.ovf    && c.ovf_irq_en) ||
                (s.udf    && c.udf_irq_en);
    return any_cause && c.rd_en;
  endfunction

  logic req_now;
  assign req_now = irq_req(stat, ctrl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= req_now;
  end

  // R6: a raised request always had reader enable in the cycle before
  a_r6_irq_needs_rden: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl.rd_en));
  // R6: a raised request always had at least one flag in the cycle before
  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(stat.bp_hit || stat.ovf || stat.udf));
endmodule

// File: rtl/fifo_status_irq.sv
module fifo_status_irq
  import fsi_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_ptr,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [AW-1:0]    fill_dist,
  input  logic [AW-1:0]    hi_mark,
  input  logic [AW-1:0]    lo_mark,
  input  logic [AW-1:0]    bp_addr,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic             irq,
  output logic             flush,
  output logic             link_en
);
  ctrl_t ctrl;
  stat_t stat;
  logic  unused_hi_bits;

  assign unused_hi_bits = ^wr_data[REG_W-1:CTRL_USED];

  fsi_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bits (wr_data[CTRL_USED-1:0]),
    .ctrl    (ctrl),
    .flush   (flush)
  );

  fsi_flag_eval #(.AW(AW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .fill_dist (fill_dist),
    .hi_mark   (hi_mark),
    .lo_mark   (lo_mark),
    .bp_addr   (bp_addr),
    .ctrl      (ctrl),
    .stat      (stat)
  );

  fsi_irq_gen u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (stat),
    .ctrl  (ctrl),
    .irq   (irq)
  );

  assign rd_data = (rd_addr == ADDR_STAT) ? pack_stat(stat) : pack_ctrl(ctrl);
  assign link_en = ctrl.link_en;

  // R7: reserved control bits never read back set
  a_r7_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_CTRL) |-> (rd_data[REG_W-1:CTRL_USED] == '0));
  // R8: reserved status bits never read back set
  a_r8_stat_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_STAT) |-> (rd_data[REG_W-1:STAT_USED] == '0));
endmodule

// File: tb/fifo_status_irq_tb.sv
module fifo_status_irq_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rd_ptr = '0, wr_ptr = '0, fill_dist = '0;
  logic [AW-1:0] hi_mark = '0, lo_mark = '0, bp_addr = 16'd5;
  logic          wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic          irq, flush, link_en;

  int n_checks = 0;
  int n_bad = 0;
  logic [5:0] e_ctrl = '0;
  logic       e_irq = 1'b0;
  logic       e_flush = 1'b0;
  int unsigned seed = 32'd20240611;

  always #4 clk = ~clk;

  fifo_status_irq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .fill_dist(fill_dist), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .bp_addr(bp_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .flush(flush),
    .link_en(link_en)
  );

  function automatic logic [4:0] ref_stat(input logic [5:0] c);
    logic o, u, b, ri, ci;
    o  = fill_dist > hi_mark;
    u  = lo_mark > fill_dist;
    b  = c[1] && (rd_ptr == bp_addr);
    ri = (fill_dist == 0) || (wr_ptr == rd_ptr);
    ci = (fill_dist == 0) || b || (c[0] == 1'b0);
    return {b, ci, ri, u, o};
  endfunction

  function automatic logic ref_irq(input logic [5:0] c);
    logic [4:0] s;
    s = ref_stat(c);
    if (!c[0]) return 1'b0;
    return (s[4] & c[5]) | (s[0] & c[2]) | (s[1] & c[3]);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [4:0] s;
    s = ref_stat(e_ctrl);
    rd_addr = 1'b1; #1;
    check("R1 overflow",   {15'd0, rd_data[0]}, {15'd0, s[0]});
    check("R2 underflow",  {15'd0, rd_data[1]}, {15'd0, s[1]});
    check("R4 read idle",  {15'd0, rd_data[2]}, {15'd0, s[2]});
    check("R5 cmd idle",   {15'd0, rd_data[3]}, {15'd0, s[3]});
    check("R3 stop hit",   {15'd0, rd_data[4]}, {15'd0, s[4]});
    check("R8 stat upper", {5'd0, rd_data[15:5]}, 16'd0);
    rd_addr = 1'b0; #1;
    check("R7 ctrl word", rd_data, {10'd0, e_ctrl});
    check("R7 link_en", {15'd0, link_en}, {15'd0, e_ctrl[4]});
    check("R6 irq", {15'd0, irq}, {15'd0, e_irq});
    check("R9 flush", {15'd0, flush}, {15'd0, e_flush});
  endtask

  // inputs applied at negedge; one edge; then outputs checked at next negedge
  task automatic step(input logic we, input logic wa, input logic [15:0] wd);
    logic [5:0] n_ctrl;
    logic       n_irq, n_flush;
    wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    n_irq   = ref_irq(e_ctrl);
    n_flush = we && !wa && e_ctrl[0] && !wd[0];
    n_ctrl  = (we && !wa) ? wd[5:0] : e_ctrl;
    @(posedge clk);
    e_ctrl = n_ctrl; e_irq = n_irq; e_flush = n_flush;
    @(negedge clk);
    wr_en = 1'b0;
    check_all();
  endtask

  task automatic rand_inputs();
    rd_ptr    = 16'($urandom_range(0, 5));
    wr_ptr    = 16'($urandom_range(0, 5));
    bp_addr   = 16'($urandom_range(0, 5));
    fill_dist = 16'($urandom_range(0, 9));
    hi_mark   = 16'($urandom_range(0, 9));
    lo_mark   = 16'($urandom_range(0, 9));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_checks++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    rd_addr = 1'b1; #1;
    check("R10 reset status", rd_data, 16'h000C);
    rd_addr = 1'b0; #1;
    check("R10 reset ctrl", rd_data, 16'h0000);
    check("R10 reset irq", {15'd0, irq}, 16'd0);
    check("R10 reset flush", {15'd0, flush}, 16'd0);

    // R7: reserved bits dropped, all fields set
    step(1'b1, 1'b0, 16'hFFFF);
    // R8: status write ignored
    step(1'b1, 1'b1, 16'h0000);
    check("R8 ctrl kept", rd_data, 16'h003F);
    // R9: reader enable removed while set -> pulse
    step(1'b1, 1'b0, 16'h0002);
    check("R9 pulse seen", {15'd0, flush}, 16'd1);
    step(1'b0, 1'b0, 16'h0000);
    check("R9 pulse ends", {15'd0, flush}, 16'd0);
    // R9: clearing an already clear enable -> no pulse
    step(1'b1, 1'b0, 16'h0000);
    check("R9 no pulse", {15'd0, flush}, 16'd0);

    // R3 R6: directed stop interrupt
    rd_ptr = 16'd3; bp_addr = 16'd3; fill_dist = 16'd2; hi_mark = 16'd8;
    lo_mark = 16'd1; wr_ptr = 16'd4;
    step(1'b1, 1'b0, 16'h0023);
    step(1'b0, 1'b0, 16'h0000);
    check("R6 stop irq", {15'd0, irq}, 16'd1);
    // R1 R2: both thresholds crossed at once (low above high)
    fill_dist = 16'd5; hi_mark = 16'd2; lo_mark = 16'd7;
    step(1'b1, 1'b0, 16'h000D);
    step(1'b0, 1'b0, 16'h0000);

    for (int i = 0; i < 3000; i++) begin
      logic we;
      rand_inputs();
      we = ($urandom_range(0, 3) == 0);
      step(we, 1'($urandom_range(0, 1)), 16'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule